// File: doc/BRIEF.md
# Host-to-Controller Mailbox with Status Flags

This block is a one-byte mailbox between a host and a local microcontroller. The host writes bytes through two strobed write ports: one for data and one for commands. It reads back the reply byte through a strobed data read, and it can always see an eight-bit status word. The local side reads the host byte, writes a reply byte, writes its own software status flags, and manages a small interrupt source register with a mask.

The hardware keeps three flags. Input-full means the host has sent a byte that the local side has not yet read. Output-full means the local side has posted a reply that the host has not yet read. The command marker tells whether the last host byte came through the command port or the data port. Two interrupt sources are latched from flag edges. One is raised when output-full drops, which tells the local side that the host has taken the reply. The other is raised when input-full rises, which tells the local side that a new byte has arrived.

Top module: `mailbox_status`

## Requirements
- R1: After reset the status word, the interrupt source register, the mask register, both data bytes and `loc_irq` are all zero.
- R2: The status word has a fixed layout: bit 0 is output-full, bit 1 is input-full, bit 2 is a software bit, bit 3 is the command marker, and bits 4 to 7 are software bits (burst mode at bit 4, two event flags at bits 5 and 6, and a spare bit at 7). The host sees the same value on `host_status` that the local side sees on `loc_status`, and the host cannot write it.
- R3: A `loc_wr_data` pulse stores `loc_wdata` as the reply byte on `host_rdata` and sets output-full at the next edge. A `host_rd_data` pulse clears output-full at the next edge.
- R4: A host write through either port stores `host_wdata` on `loc_rdata` and sets input-full. A `loc_rd_data` pulse clears input-full. A host write while input-full is already set replaces the byte and leaves the flag set.
- R5: A command-port write sets the command marker. A data-port write clears it. If both ports are written in the same cycle, the command port wins.
- R6: A `loc_wr_status` pulse loads bits 7, 6, 5, 4 and 2 from `loc_wdata`. Bits 3, 1 and 0 of that write are ignored. The hardware never changes the software bits.
- R7: Source bit 4 is set in the same edge in which output-full goes from 1 to 0, and only then.
- R8: Source bit 5 is set in the same edge in which input-full goes from 0 to 1. An overwrite while input-full is already set does not raise it again.
- R9: Writing 1s with `loc_clr_src` clears the matching source bits. A source set in the same cycle as its clear wins. Source bits other than 4 and 5 always read 0.
- R10: A `loc_wr_mask` pulse loads the mask register. `loc_irq` is high when any source bit is set and its mask bit is also set.
- R11: When a flag set and a flag clear happen in the same cycle, the flag ends up set and no edge interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_wr_data | input | 1 | Host write strobe, data port |
| host_wr_cmd | input | 1 | Host write strobe, command port |
| host_wdata | input | 8 | Host write byte |
| host_rd_data | input | 1 | Host read strobe, data port |
| host_rdata | output | 8 | Reply byte for the host |
| host_status | output | 8 | Status word as the host sees it |
| loc_rd_data | input | 1 | Local read strobe for the host byte |
| loc_wr_data | input | 1 | Local write strobe, reply byte |
| loc_wr_status | input | 1 | Local write strobe, software status bits |
| loc_wr_mask | input | 1 | Local write strobe, interrupt mask |
| loc_clr_src | input | 1 | Local write-one-to-clear strobe, interrupt sources |
| loc_wdata | input | 8 | Local write byte |
| loc_rdata | output | 8 | Last byte written by the host |
| loc_status | output | 8 | Status word as the local side sees it |
| loc_int_src | output | 8 | Interrupt source register |
| loc_int_mask | output | 8 | Interrupt mask register |
| loc_irq | output | 1 | Interrupt request to the local side |

## Verification
The bench builds the block with its default source positions: output-full drives source bit 4 and input-full drives source bit 5. With those defaults, the exact bit positions in the requirements can be checked directly at the ports. That includes the edge sources that land in a known bit while the other source bits stay zero. It also includes collisions in the same cycle between set and clear on each flag and on each source bit. Because the strobes are single cycles, each edge and each overwrite can be placed in a chosen cycle.

// File: rtl/mailbox_status.sv
module mailbox_status #(
  parameter int OBF_SRC = 4,
  parameter int IBF_SRC = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr_data,
  input  logic       host_wr_cmd,
  input  logic [7:0] host_wdata,
  input  logic       host_rd_data,
  output logic [7:0] host_rdata,
  output logic [7:0] host_status,
  input  logic       loc_rd_data,
  input  logic       loc_wr_data,
  input  logic       loc_wr_status,
  input  logic       loc_wr_mask,
  input  logic       loc_clr_src,
  input  logic [7:0] loc_wdata,
  output logic [7:0] loc_rdata,
  output logic [7:0] loc_status,
  output logic [7:0] loc_int_src,
  output logic [7:0] loc_int_mask,
  output logic       loc_irq
);
  localparam logic [7:0] SW_BITS = 8'hF4;
  localparam logic [7:0] SRC_IMPL = (8'h1 << OBF_SRC) | (8'h1 << IBF_SRC);

  logic       obf_q, ibf_q, cmd_q;
  logic [7:0] sw_q, in_byte_q, out_byte_q, src_q, mask_q;
  logic       host_wr, obf_d, ibf_d;
  logic [7:0] src_set, src_clr;

  assign host_wr = host_wr_data | host_wr_cmd;
  assign obf_d   = loc_wr_data ? 1'b1 : (host_rd_data ? 1'b0 : obf_q);
  assign ibf_d   = host_wr ? 1'b1 : (loc_rd_data ? 1'b0 : ibf_q);

  always_comb begin
    src_set = '0;
    src_set[OBF_SRC] = obf_q & ~obf_d;
    src_set[IBF_SRC] = ~ibf_q & ibf_d;
    src_clr = loc_clr_src ? loc_wdata : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      obf_q      <= 1'b0;
      ibf_q      <= 1'b0;
      cmd_q      <= 1'b0;
      sw_q       <= '0;
      in_byte_q  <= '0;
      out_byte_q <= '0;
      src_q      <= '0;
      mask_q     <= '0;
    end else begin
      obf_q <= obf_d;
      ibf_q <= ibf_d;
      if (host_wr) begin
        in_byte_q <= host_wdata;
        cmd_q     <= host_wr_cmd;
      end
      if (loc_wr_data) out_byte_q <= loc_wdata;
      if (loc_wr_status) sw_q <= loc_wdata & SW_BITS;
      if (loc_wr_mask) mask_q <= loc_wdata;
      src_q <= ((src_q & ~src_clr) | src_set) & SRC_IMPL;
    end
  end

  assign loc_status   = sw_q | {4'b0000, cmd_q, 1'b0, ibf_q, obf_q};
  assign host_status  = loc_status;
  assign host_rdata   = out_byte_q;
  assign loc_rdata    = in_byte_q;
  assign loc_int_src  = src_q;
  assign loc_int_mask = mask_q;
  assign loc_irq      = |(src_q & mask_q);
endmodule

module mailbox_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_wr_data,
  input logic       host_wr_cmd,
  input logic [7:0] host_wdata,
  input logic       host_rd_data,
  input logic [7:0] host_rdata,
  input logic [7:0] host_status,
  input logic       loc_rd_data,
  input logic       loc_wr_data,
  input logic       loc_wr_status,
  input logic       loc_wr_mask,
  input logic       loc_clr_src,
  input logic [7:0] loc_wdata,
  input logic [7:0] loc_rdata,
  input logic [7:0] loc_status,
  input logic [7:0] loc_int_src,
  input logic [7:0] loc_int_mask,
  input logic       loc_irq
);
  AST_HOST_WR_SETS_IBF: assert property (@(posedge clk) disable iff (!rst_n) (host_wr_data | host_wr_cmd) |=> host_status[1]); // R4
  AST_LOC_WR_SETS_OBF: assert property (@(posedge clk) disable iff (!rst_n) loc_wr_data |=> host_status[0]); // R3
  AST_CMD_PORT_MARK: assert property (@(posedge clk) disable iff (!rst_n) host_wr_cmd |=> host_status[3]); // R5
  AST_DATA_PORT_MARK: assert property (@(posedge clk) disable iff (!rst_n) (host_wr_data && !host_wr_cmd) |=> !host_status[3]); // R5
  AST_SW_BITS_HELD: assert property (@(posedge clk) disable iff (!rst_n) !loc_wr_status |=> $stable({loc_status[7:4], loc_status[2]})); // R6
  AST_OBF_FALL_SRC: assert property (@(posedge clk) disable iff (!rst_n) $fell(loc_status[0]) |-> loc_int_src[4]); // R7
  AST_IBF_RISE_SRC: assert property (@(posedge clk) disable iff (!rst_n) $rose(loc_status[1]) |-> loc_int_src[5]); // R8
  AST_SRC_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (loc_int_src[3:0] == 4'h0) && (loc_int_src[7:6] == 2'b00)); // R9
  AST_SRC_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n) (!loc_int_src[4] && !(loc_status[0] && host_rd_data && !loc_wr_data)) |=> !loc_int_src[4]); // R7
  AST_HOST_VIEW_SAME: assert property (@(posedge clk) disable iff (!rst_n) host_status == loc_status); // R2
endmodule

bind mailbox_status mailbox_status_chk u_chk (.*);

// File: tb/mailbox_status_bench.sv
`timescale 1ns/1ps
module mailbox_status_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic host_wr_data = 0, host_wr_cmd = 0, host_rd_data = 0;
  logic [7:0] host_wdata = 0, loc_wdata = 0;
  logic loc_rd_data = 0, loc_wr_data = 0, loc_wr_status = 0, loc_wr_mask = 0, loc_clr_src = 0;
  logic [7:0] host_rdata, host_status, loc_rdata, loc_status, loc_int_src, loc_int_mask;
  logic loc_irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mailbox_status u_mailbox_status (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    host_wr_data = 0; host_wr_cmd = 0; host_rd_data = 0;
    loc_rd_data = 0; loc_wr_data = 0; loc_wr_status = 0; loc_wr_mask = 0; loc_clr_src = 0;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic t_reset();
    chk("R1 status", loc_status, 8'h00);
    chk("R1 src", loc_int_src, 8'h00);
    chk("R1 mask", loc_int_mask, 8'h00);
    chk("R1 bytes", {host_rdata | loc_rdata}, 8'h00);
    chk("R1 irq", {7'd0, loc_irq}, 8'h00);
  endtask

  task automatic t_reply();
    loc_wdata = 8'hA5; loc_wr_data = 1; step();
    chk("R3 obf set", host_status, 8'h01);
    chk("R3 reply byte", host_rdata, 8'hA5);
    chk("R7 no src on set", loc_int_src, 8'h00);
    host_rd_data = 1; step();
    chk("R3 obf clear", host_status, 8'h00);
    chk("R7 src4 on fall", loc_int_src, 8'h10);
    chk("R10 masked off", {7'd0, loc_irq}, 8'h00);
    loc_wdata = 8'h10; loc_wr_mask = 1; step();
    chk("R10 mask reg", loc_int_mask, 8'h10);
    chk("R10 irq", {7'd0, loc_irq}, 8'h01);
    host_rd_data = 1; step();
    chk("R7 no src when obf already 0", loc_int_src, 8'h10);
    loc_wdata = 8'h10; loc_clr_src = 1; step();
    chk("R9 w1c", loc_int_src, 8'h00);
    chk("R10 irq drops", {7'd0, loc_irq}, 8'h00);
  endtask

  task automatic t_host_in();
    host_wdata = 8'h3C; host_wr_data = 1; step();
    chk("R4 ibf set", loc_status, 8'h02);
    chk("R4 byte", loc_rdata, 8'h3C);
    chk("R8 src5 on rise", loc_int_src, 8'h20);
    loc_wdata = 8'h20; loc_clr_src = 1; step();
    chk("R9 clear src5", loc_int_src, 8'h00);
    host_wdata = 8'h81; host_wr_cmd = 1; step();
    chk("R4 R5 overwrite cmd", loc_status, 8'h0A);
    chk("R4 overwrite byte", loc_rdata, 8'h81);
    chk("R8 no re-raise", loc_int_src, 8'h00);
    loc_rd_data = 1; step();
    chk("R4 ibf clear", loc_status, 8'h08);
    chk("R8 no src on fall", loc_int_src, 8'h00);
  endtask

  task automatic t_soft();
    loc_wdata = 8'hFF; loc_wr_status = 1; step();
    chk("R6 R2 sw bits", loc_status, 8'hFC);
    chk("R2 host view", host_status, 8'hFC);
    host_wdata = 8'h55; host_wr_data = 1; step();
    chk("R6 hw leaves sw bits", loc_status, 8'hF6);
    loc_rd_data = 1; step();
    loc_wdata = 8'h0B; loc_wr_status = 1; step();
    chk("R6 hw bits ignored", loc_status, 8'h00);
    loc_wdata = 8'h30; loc_clr_src = 1; step();
  endtask

  task automatic t_collide();
    loc_wdata = 8'h77; loc_wr_data = 1; step();
    loc_wdata = 8'h78; loc_wr_data = 1; host_rd_data = 1; step();
    chk("R11 obf stays set", host_status, 8'h01);
    chk("R11 no src4", loc_int_src, 8'h00);
    chk("R3 new reply", host_rdata, 8'h78);
    host_wdata = 8'h11; host_wr_data = 1; host_wr_cmd = 1; loc_wdata = 8'h20; loc_clr_src = 1; step();
    chk("R5 both ports cmd wins", host_status, 8'h0B);
    chk("R9 set beats clear", loc_int_src, 8'h20);
    host_wdata = 8'h22; host_wr_data = 1; loc_rd_data = 1; step();
    chk("R11 ibf stays set", host_status, 8'h03);
    chk("R5 data port clears", {7'd0, host_status[3]}, 8'h00);
    loc_wdata = 8'hFF; loc_wr_mask = 1; step();
    loc_wdata = 8'hCF; loc_clr_src = 1; step();
    chk("R9 unused src zero", loc_int_src, 8'h20);
    chk("R10 irq all mask", {7'd0, loc_irq}, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_reply();
    t_host_in();
    t_soft();
    t_collide();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule